// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the two error counters of a CAN node and decides the node's fault-confinement state from them. The protocol engine sends it one-cycle event pulses: transmit error, receive error, frame sent, frame received, and "eleven recessive bits seen". A transmit error raises the transmit counter by 8. A receive error raises the receive counter by 1. Each good frame lowers the matching counter by one, and a counter never drops below zero. From the counter values the block selects error-active, error-passive or bus-off.

When the transmit counter would pass its maximum, the node goes to bus-off and both counters clear. Recovery then starts in one of two ways. It starts on its own when the automatic-recovery control bit is set. Otherwise it waits until software sets a one-shot recovery request. During recovery the receive counter counts the runs of eleven recessive bits. On the 128th run the node returns to error-active with both counters clear, and the request bit clears itself. In snoop mode the node only listens, and both counters stay at zero.

The state machine has five states. CONFIG is held while enable is low or soft reset is high. ACTIVE and PASSIVE are the two counting states. BUSOFF waits for permission to recover. RECOVER counts the idle runs. The transitions are:
- config-exit: CONFIG to ACTIVE when enabled.
- go-passive: ACTIVE to PASSIVE.
- go-active: PASSIVE to ACTIVE.
- go-busoff: ACTIVE or PASSIVE to BUSOFF.
- start-recovery: BUSOFF to RECOVER.
- recovery-done: RECOVER to ACTIVE.
- hold: any state to CONFIG.

Top module: `can_fault_confine`

## Requirements
- R1: The `state_code` output reads 2'b00 in CONFIG, 2'b01 in ACTIVE, 2'b11 in PASSIVE, and 2'b10 in both BUSOFF and RECOVER.
- R2: A clock edge with `rst_n` low, `enable` low or `soft_rst` high puts the block in CONFIG and clears both counters. The first edge with `enable` high and no reset takes the block from CONFIG to ACTIVE.
- R3: In ACTIVE or PASSIVE, `tx_err` adds 8 to the transmit counter and `rx_err` adds 1 to the receive counter. On an edge where an error and the matching success pulse are both high, the error takes priority.
- R4: In ACTIVE or PASSIVE, `tx_ok` lowers the transmit counter by 1 and `rx_ok` lowers the receive counter by 1. A counter already at 0 stays at 0. The receive counter saturates at 255.
- R5: The block is in PASSIVE after an edge that leaves either counter above 127. It is in ACTIVE after an edge that leaves both counters at 127 or below.
- R6: `warn` is high exactly when either visible counter is 96 or more.
- R7: If a transmit error would take the transmit counter above 255, the block goes to BUSOFF instead, clears both counters, and raises `busoff_evt` for exactly that one cycle.
- R8: In BUSOFF, the block moves to RECOVER on the next edge while `auto_rec` is high. Otherwise it stays in BUSOFF.
- R9: `man_rec_req` sets `man_rec_pend` only while the block is in BUSOFF; it is ignored in every other state. While the flag is high, the block moves from BUSOFF to RECOVER on the next edge.
- R10: In RECOVER, each `idle11` pulse raises the receive counter by 1. The pulse that would make the count 128 returns the block to ACTIVE instead, with both counters at 0, raises `recov_done_evt` for one cycle, and clears `man_rec_pend`. The `recovering` output is high only in RECOVER. `idle11` is ignored outside RECOVER, and error and success pulses are ignored in BUSOFF and RECOVER.
- R11: While `snoop` is high, `tec` and `rec` read 0. While `snoop` is high in ACTIVE or PASSIVE, the internal counters clear, error pulses have no effect, and the block stays in ACTIVE.
- R12: `man_rec_pend` clears on reset, on soft reset and when `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Node enable; low holds CONFIG |
| soft_rst | input | 1 | Software reset, holds CONFIG |
| snoop | input | 1 | Listen-only mode, counters held at zero |
| auto_rec | input | 1 | Recover from bus-off without software |
| man_rec_req | input | 1 | Software recovery request pulse |
| tx_err | input | 1 | Transmit error event |
| rx_err | input | 1 | Receive error event |
| tx_ok | input | 1 | Successful transmit event |
| rx_ok | input | 1 | Successful receive event |
| idle11 | input | 1 | Run of eleven recessive bits seen |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter (recovery run count in RECOVER) |
| state_code | output | 2 | Fault confinement state code |
| warn | output | 1 | Either counter at 96 or above |
| recovering | output | 1 | Bus-off recovery in progress |
| busoff_evt | output | 1 | One-cycle pulse on bus-off entry |
| recov_done_evt | output | 1 | One-cycle pulse when recovery completes |
| man_rec_pend | output | 1 | Self-clearing software recovery request |

## Verification
The assertions assume that `snoop` is raised only while the node is in CONFIG, ACTIVE or PASSIVE and never while it is in BUSOFF or RECOVER. They also assume that every event input is sampled as a single-cycle level at each edge. The stimulus raises snoop only when the bench's own model is in a counting state. Bus-off episodes use snoop low throughout. The event rates are chosen so that the node reaches bus-off often and each recovery finishes in a few hundred cycles.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [2:0] {
        FC_CONFIG,
        FC_ACTIVE,
        FC_PASSIVE,
        FC_BUSOFF,
        FC_RECOVER
    } fc_state_e;

    localparam logic [1:0] CODE_CONFIG  = 2'b00;
    localparam logic [1:0] CODE_ACTIVE  = 2'b01;
    localparam logic [1:0] CODE_PASSIVE = 2'b11;
    localparam logic [1:0] CODE_BUSOFF  = 2'b10;

    // BUSOFF and RECOVER share the bus-off code
    function automatic logic [1:0] fc_code(input fc_state_e s);
        logic [1:0] c;
        unique case (s)
            FC_CONFIG:  c = CODE_CONFIG;
            FC_ACTIVE:  c = CODE_ACTIVE;
            FC_PASSIVE: c = CODE_PASSIVE;
            FC_BUSOFF:  c = CODE_BUSOFF;
            FC_RECOVER: c = CODE_BUSOFF;
            default:    c = CODE_CONFIG;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
    parameter int W   = 8,
    parameter int INC = 1,
    parameter int LIM = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bump,
    input  logic         relax,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         over_next
);
    localparam logic [W:0]   MAXV = {1'b0, {W{1'b1}}};
    localparam logic [W:0]   INCV = (W+1)'(INC);
    localparam logic [W-1:0] LIMV = W'(LIM);

    logic [W:0]   sum;
    logic [W-1:0] nxt;

    // Saturating add on error, floored decrement on success, +1 on step
    always_comb begin
        sum = {1'b0, cnt} + INCV;
        nxt = cnt;
        if (bump) begin
            nxt = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
        end else if (relax) begin
            nxt = (cnt != '0) ? cnt - 1'b1 : cnt;
        end else if (step) begin
            nxt = (cnt == MAXV[W-1:0]) ? cnt : cnt + 1'b1;
        end
    end

    assign over_next = (nxt > LIMV);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= nxt;
    end
endmodule

// File: rtl/fc_req_latch.sv
module fc_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    input  logic accept,
    output logic pend
);
    // Clear wins over a simultaneous accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)             pend <= 1'b0;
        else if (clr)           pend <= 1'b0;
        else if (req && accept) pend <= 1'b1;
    end
endmodule

// File: rtl/fc_fsm.sv
module fc_fsm
    import fc_pkg::*;
#(
    parameter int W      = 8,
    parameter int TX_INC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         soft_rst,
    input  logic         snoop,
    input  logic         auto_rec,
    input  logic         man_pend,
    input  logic         tx_err,
    input  logic [W-1:0] tec,
    input  logic         pass_next,
    input  logic         rec_last,
    input  logic         idle11,
    output fc_state_e    state,
    output logic         cnt_run,
    output logic         cnt_clr,
    output logic         rec_step,
    output logic         finish,
    output logic         busoff_p,
    output logic         done_p
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};
    localparam logic [W:0] INCV = (W+1)'(TX_INC);

    fc_state_e nstate;
    logic      hold;
    logic      counting;
    logic      tx_wrap;

    assign hold     = !enable || soft_rst;
    assign counting = (state == FC_ACTIVE) || (state == FC_PASSIVE);
    assign cnt_run  = counting && !snoop;
    assign tx_wrap  = cnt_run && tx_err && (({1'b0, tec} + INCV) > MAXV);
    assign finish   = (state == FC_RECOVER) && idle11 && rec_last;
    assign rec_step = (state == FC_RECOVER) && idle11 && !rec_last;
    assign cnt_clr  = hold || tx_wrap || finish || (counting && snoop);

    // Next-state logic
    always_comb begin
        nstate = state;
        if (hold) begin
            nstate = FC_CONFIG;
        end else begin
            unique case (state)
                FC_CONFIG:  nstate = FC_ACTIVE;
                FC_ACTIVE,
                FC_PASSIVE: begin
                    if (snoop)          nstate = FC_ACTIVE;
                    else if (tx_wrap)   nstate = FC_BUSOFF;
                    else if (pass_next) nstate = FC_PASSIVE;
                    else                nstate = FC_ACTIVE;
                end
                FC_BUSOFF:  nstate = (auto_rec || man_pend) ? FC_RECOVER : FC_BUSOFF;
                FC_RECOVER: nstate = finish ? FC_ACTIVE : FC_RECOVER;
                default:    nstate = FC_CONFIG;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FC_CONFIG;
        else        state <= nstate;
    end

    // Registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busoff_p <= 1'b0;
            done_p   <= 1'b0;
        end else begin
            busoff_p <= !hold && tx_wrap;
            done_p   <= !hold && finish;
        end
    end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TX_INC      = 8,
    parameter int RX_INC      = 1,
    parameter int PASSIVE_LIM = 127,
    parameter int WARN_LIM    = 96,
    parameter int RECOV_RUNS  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             soft_rst,
    input  logic             snoop,
    input  logic             auto_rec,
    input  logic             man_rec_req,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             idle11,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       state_code,
    output logic             warn,
    output logic             recovering,
    output logic             busoff_evt,
    output logic             recov_done_evt,
    output logic             man_rec_pend
);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RECOV_RUNS - 1);
    localparam logic [CNT_W-1:0] WARN_V   = CNT_W'(WARN_LIM);

    fc_state_e        state;
    logic             cnt_run, cnt_clr, rec_step, finish;
    logic             tx_over, rx_over;
    logic [CNT_W-1:0] tec_q, rec_q;
    logic             hold;

    assign hold = !enable || soft_rst;

    fc_err_counter #(.W(CNT_W), .INC(TX_INC), .LIM(PASSIVE_LIM)) u_tx_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .bump      (cnt_run && tx_err),
        .relax     (cnt_run && tx_ok),
        .step      (1'b0),
        .cnt       (tec_q),
        .over_next (tx_over)
    );

    fc_err_counter #(.W(CNT_W), .INC(RX_INC), .LIM(PASSIVE_LIM)) u_rx_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .bump      (cnt_run && rx_err),
        .relax     (cnt_run && rx_ok),
        .step      (rec_step),
        .cnt       (rec_q),
        .over_next (rx_over)
    );

    fc_fsm #(.W(CNT_W), .TX_INC(TX_INC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .soft_rst  (soft_rst),
        .snoop     (snoop),
        .auto_rec  (auto_rec),
        .man_pend  (man_rec_pend),
        .tx_err    (tx_err),
        .tec       (tec_q),
        .pass_next (tx_over || rx_over),
        .rec_last  (rec_q == RUN_LAST),
        .idle11    (idle11),
        .state     (state),
        .cnt_run   (cnt_run),
        .cnt_clr   (cnt_clr),
        .rec_step  (rec_step),
        .finish    (finish),
        .busoff_p  (busoff_evt),
        .done_p    (recov_done_evt)
    );

    fc_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hold || finish),
        .req    (man_rec_req),
        .accept (state == FC_BUSOFF),
        .pend   (man_rec_pend)
    );

    assign tec        = snoop ? '0 : tec_q;
    assign rec        = snoop ? '0 : rec_q;
    assign state_code = fc_code(state);
    assign recovering = (state == FC_RECOVER);
    assign warn       = (tec >= WARN_V) || (rec >= WARN_V);
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       snoop,
    input logic [7:0] tec,
    input logic [7:0] rec,
    input logic [1:0] state_code,
    input logic       recovering,
    input logic       busoff_evt,
    input logic       recov_done_evt,
    input logic       man_rec_pend
);
    // R2: configuration state holds cleared counters and no request
    a_r2_config_clear: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b00 |-> (tec == 8'd0 && rec == 8'd0 && !man_rec_pend));

    // R5: the passive code only with a counter above 127
    a_r5_passive_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b11 && !snoop) |-> (tec > 8'd127 || rec > 8'd127));

    // R7: bus-off entry pulse comes with cleared counters and bus-off code
    a_r7_busoff_entry: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_evt |-> (state_code == 2'b10 && tec == 8'd0 && rec == 8'd0 && !recovering));

    // R7: the entry pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_evt |=> !busoff_evt);

    // R10: recovery completion lands in error-active with request cleared
    a_r10_done_active: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done_evt |-> (state_code == 2'b01 && rec == 8'd0 && !man_rec_pend));

    // R10: the recovery flag is seen only under the bus-off code
    a_r10_recover_code: assert property (@(posedge clk) disable iff (!rst_n)
        recovering |-> state_code == 2'b10);

    // R9: a request is latched only out of the bus-off waiting state
    a_r9_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(man_rec_pend) |-> ($past(state_code) == 2'b10 && !$past(recovering)));

    // R11: a held snoop keeps the node out of passive and bus-off
    a_r11_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop && $past(snoop)) |-> (state_code != 2'b11 && !busoff_evt));
endmodule

bind can_fault_confine fc_checker u_fc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .snoop          (snoop),
    .tec            (tec),
    .rec            (rec),
    .state_code     (state_code),
    .recovering     (recovering),
    .busoff_evt     (busoff_evt),
    .recov_done_evt (recov_done_evt),
    .man_rec_pend   (man_rec_pend)
);

// File: tb/sim_can_fault_confine.sv
`timescale 1ns/1ps
module sim_can_fault_confine;
    logic clk = 1'b0;
    logic rst_n = 1'b0, enable = 1'b0, soft_rst = 1'b0, snoop = 1'b0;
    logic auto_rec = 1'b0, man_rec_req = 1'b0;
    logic tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0, idle11 = 1'b0;
    logic [7:0] tec, rec;
    logic [1:0] state_code;
    logic warn, recovering, busoff_evt, recov_done_evt, man_rec_pend;

    int checks = 0;
    int errors = 0;

    // model: 0 config, 1 active, 2 passive, 3 bus-off, 4 recover
    int ms = 0, mt = 0, mr = 0, mm = 0, mbo = 0, mdn = 0;

    always #2.5 clk = ~clk;

    can_fault_confine u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
        .snoop(snoop), .auto_rec(auto_rec), .man_rec_req(man_rec_req),
        .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .idle11(idle11), .tec(tec), .rec(rec), .state_code(state_code),
        .warn(warn), .recovering(recovering), .busoff_evt(busoff_evt),
        .recov_done_evt(recov_done_evt), .man_rec_pend(man_rec_pend)
    );

    function automatic int code_of(input int s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int nt, nr;
        mbo = 0;
        mdn = 0;
        if (!rst_n || !enable || soft_rst) begin
            ms = 0; mt = 0; mr = 0; mm = 0;
        end else begin
            case (ms)
                0: ms = 1;
                1, 2: begin
                    if (snoop) begin
                        mt = 0; mr = 0; ms = 1;
                    end else begin
                        nt = mt; nr = mr;
                        if (tx_err) nt = nt + 8;
                        else if (tx_ok && nt > 0) nt = nt - 1;
                        if (rx_err) nr = (nr == 255) ? 255 : nr + 1;
                        else if (rx_ok && nr > 0) nr = nr - 1;
                        if (nt > 255) begin
                            ms = 3; mt = 0; mr = 0; mbo = 1;
                        end else begin
                            mt = nt; mr = nr;
                            ms = (nt > 127 || nr > 127) ? 2 : 1;
                        end
                    end
                end
                3: begin
                    if (auto_rec || mm != 0) ms = 4;
                    if (man_rec_req) mm = 1;
                end
                default: begin
                    if (idle11) begin
                        if (mr == 127) begin
                            ms = 1; mr = 0; mt = 0; mm = 0; mdn = 1;
                        end else begin
                            mr = mr + 1;
                        end
                    end
                end
            endcase
        end
    endtask

    task automatic compare_all();
        int et, er;
        et = snoop ? 0 : mt;
        er = snoop ? 0 : mr;
        chk("R3 tec", tec, et);
        chk("R4 rec", rec, er);
        chk("R1 state_code", state_code, code_of(ms));
        chk("R6 warn", warn, (et >= 96 || er >= 96) ? 1 : 0);
        chk("R10 recovering", recovering, (ms == 4) ? 1 : 0);
        chk("R7 busoff_evt", busoff_evt, mbo);
        chk("R10 recov_done_evt", recov_done_evt, mdn);
        chk("R9 man_rec_pend", man_rec_pend, mm);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle11 = 0; man_rec_req = 0;
    endtask

    task automatic drive_to_busoff();
        quiet();
        tx_err = 1;
        while (ms != 3) tick();
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_c0de);
        quiet();
        @(negedge clk);
        repeat (3) tick();
        chk("R2 reset code", state_code, 0);
        chk("R2 reset tec", tec, 0);
        rst_n = 1; enable = 1;
        tick();
        chk("R2 config exit to active", state_code, 1);
        // R4 floor at zero
        tx_ok = 1; rx_ok = 1; tick(); quiet();
        chk("R4 tec floor", tec, 0);
        // R3 error beats success on the same edge
        tx_err = 1; tx_ok = 1; rx_err = 1; rx_ok = 1; tick(); quiet();
        chk("R3 tie tec", tec, 8);
        chk("R3 tie rec", rec, 1);
        // R9 request ignored outside bus-off
        man_rec_req = 1; tick(); quiet(); tick();
        chk("R9 ignored in active", man_rec_pend, 0);
        // R6 warn at 96, R5 passive above 127
        tx_err = 1; repeat (11) tick(); quiet();
        chk("R6 warn at 96", warn, 1);
        tx_err = 1; repeat (4) tick(); quiet();
        chk("R5 passive at 128", state_code, 3);
        tx_ok = 1; tick(); quiet();
        chk("R5 back to active at 127", state_code, 1);
        // R7 bus-off entry, R8 no auto recovery
        drive_to_busoff();
        chk("R7 pulse", busoff_evt, 1);
        chk("R7 tec cleared", tec, 0);
        idle11 = 1; tx_err = 1; rx_err = 1; repeat (5) tick(); quiet();
        chk("R8 stays bus-off", state_code, 2);
        chk("R10 idle ignored in bus-off", rec, 0);
        // R9 manual request then R10 recovery
        man_rec_req = 1; tick(); quiet();
        chk("R9 pend set", man_rec_pend, 1);
        tick();
        chk("R9 recovery started", recovering, 1);
        idle11 = 1; repeat (127) tick();
        chk("R10 run count 127", rec, 127);
        tick(); quiet();
        chk("R10 done pulse", recov_done_evt, 1);
        chk("R10 pend cleared", man_rec_pend, 0);
        chk("R10 active after recovery", state_code, 1);
        // R12 enable low clears the request
        drive_to_busoff();
        man_rec_req = 1; tick(); quiet();
        enable = 0; tick(); enable = 1;
        chk("R12 pend cleared by enable", man_rec_pend, 0);
        chk("R12 config code", state_code, 0);
        tick();
        // R4 receive saturation
        rx_err = 1; repeat (260) tick(); quiet();
        chk("R4 rec saturates", rec, 255);
        // R11 snoop
        snoop = 1; tx_err = 1; rx_err = 1; repeat (40) tick(); quiet();
        chk("R11 snoop tec", tec, 0);
        chk("R11 snoop active", state_code, 1);
        snoop = 0; tick();
        // R8 automatic recovery
        auto_rec = 1;
        drive_to_busoff();
        tick();
        chk("R8 auto recovery", recovering, 1);
        idle11 = 1; repeat (128) tick(); quiet();
        auto_rec = 0;
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R2 soft reset", state_code, 0);

        // constrained random
        for (int i = 0; i < 40000; i++) begin
            tx_err      = ($urandom_range(99) < 20);
            tx_ok       = ($urandom_range(99) < 10);
            rx_err      = ($urandom_range(99) < 30);
            rx_ok       = ($urandom_range(99) < 20);
            idle11      = ($urandom_range(99) < 50);
            man_rec_req = ($urandom_range(99) < 2);
            enable      = !($urandom_range(999) < 2);
            soft_rst    = ($urandom_range(999) < 1);
            if ($urandom_range(999) < 3) auto_rec = !auto_rec;
            if (!snoop && (ms == 1 || ms == 2) && $urandom_range(999) < 3) snoop = 1;
            else if (snoop && $urandom_range(99) < 1) snoop = 0;
            if (snoop && ms > 2) snoop = 0;
            tick();
        end
        quiet();
        enable = 1; soft_rst = 0; snoop = 0;
        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule